// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block drives the host side of a port-mapped NAND bridge through one complete page-program operation. A one-cycle `start` pulse captures a destination address. From then on the block runs by itself and produces every host bus cycle the bridge needs. A bus cycle here means chip select and a read or write strobe on a 4-bit port address, with write data or read data and, for command writes, a command-latch strobe. The page data comes from a small external word buffer of 32-bit entries. The sequencer presents a word index and expects the selected word back in the same cycle. It then unpacks each word into bytes.

The operation is framed by bracketing cycles:
- Before programming: flash enable, ALE control, spare-area enable and removal of write protection.
- Programming proper: load command, address, 32 data bytes, then the program command and the status command.
- Afterwards: status is polled until ready, protection is restored, and the final status is read to decide pass or fail.
- Finally: the flash is deselected.

Strobe width, recovery time and the polling limit are set by configuration inputs. A timeout counts as a failure.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, and while idle, `bus_cs_n`, `bus_wr_n`, `bus_rd_n` and `bus_cmd_lat_n` are all high and `done` is low.
- R2: The first four bus cycles are writes of 00h, in this order, to these ports:
  - port 8 (select flash enable)
  - port 3 (clear ALE)
  - port 4 (enable spare area)
  - port 7 (remove write protect)
- R3: Next comes a command write of 80h to port 1. It is followed by a write of 00h to port 2 (set ALE). Then three writes to port 0 carry `dest_addr[7:0]`, `dest_addr[16:9]` and `{1'b0, dest_addr[23:17]}`. A write of 00h to port 3 (clear ALE) closes this part.
- R4: Then follow 32 writes to port 0. Data byte n is bits [8*(n mod 4)+7 : 8*(n mod 4)] of buffer word n/4, and `buf_idx` equals n/4 while byte n is issued.
- R5: After the data, command writes of 10h and then 70h go to port 1.
- R6: Status is then read from port 0 repeatedly until a read returns bit 6 set (ready).
- R7: After ready, the block issues these cycles in order:
  - a write of 00h to port 6 (restore write protect)
  - one read from port 0, whose bit 0 becomes `fail` (1 = failed)
  - a write of 00h to port 9 (deselect)
- R8: In a command write, `bus_cmd_lat_n` goes low only after the write strobe has been low for at least one cycle. It returns high at least one cycle before the strobe and chip select rise. It never goes low in any other cycle.
- R9: In every bus cycle, chip select and exactly one strobe fall together and stay low for max(`cfg_strobe_len`,3) cycles. Consecutive cycles are separated by max(`cfg_recov_len`,1)+1 idle cycles.
- R10: If `cfg_poll_limit` consecutive status reads (0 counts as 1) all lack bit 6, polling stops with `fail`=1. Protection, the final status read and deselect still follow, and `fail` stays 1.
- R11: `done` is a single-cycle pulse after the deselect cycle. `fail` is valid with it and holds until the next accepted start. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a page program |
| dest_addr | input | 24 | Destination address, captured at start |
| cfg_strobe_len | input | 8 | Strobe-active clock count (minimum 3) |
| cfg_recov_len | input | 8 | Recovery clock count (minimum 1) |
| cfg_poll_limit | input | 16 | Maximum status polls before timeout |
| buf_idx | output | 3 | Word index into the page buffer |
| buf_word | input | 32 | Buffer word at `buf_idx` (same cycle) |
| bus_cs_n | output | 1 | Bridge chip select, active low |
| bus_wr_n | output | 1 | Bridge write strobe, active low |
| bus_rd_n | output | 1 | Bridge read strobe, active low |
| bus_port | output | 4 | Bridge port address |
| bus_wdata | output | 8 | Write data to the bridge |
| bus_rdata | input | 8 | Read data from the bridge |
| bus_cmd_lat_n | output | 1 | Command-latch strobe, active low |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result: 1 = program failed or timed out |

## Verification
The embedded assertions check on every cycle:
- the command-latch strobe stays nested inside the write strobe and opens late and closes early;
- a request reaches the cycle engine only when it is idle;
- read and write strobes never overlap;
- `done` lasts one cycle;
- the poll counter stays below the timeout limit.

Only the bench scenarios can show the rest. That covers the exact order of the 50-odd bus cycles and their port and data values, the byte unpacking from buffer words, and the split between ready-after-N-polls, a reported failure bit and a timeout. It also covers the measured strobe and gap lengths under different settings and a start pulse that arrives mid-operation.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam logic [3:0] PORT_DATA     = 4'h0;
    localparam logic [3:0] PORT_CMD      = 4'h1;
    localparam logic [3:0] PORT_ALE_SET  = 4'h2;
    localparam logic [3:0] PORT_ALE_CLR  = 4'h3;
    localparam logic [3:0] PORT_SPARE_ON = 4'h4;
    localparam logic [3:0] PORT_WP_ON    = 4'h6;
    localparam logic [3:0] PORT_WP_OFF   = 4'h7;
    localparam logic [3:0] PORT_CE_ON    = 4'h8;
    localparam logic [3:0] PORT_CE_OFF   = 4'h9;

    localparam logic [7:0] OP_LOAD   = 8'h80;
    localparam logic [7:0] OP_PROG   = 8'h10;
    localparam logic [7:0] OP_STATUS = 8'h70;

    localparam int READY_BIT = 6;
    localparam int FAIL_BIT  = 0;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACT,
        PH_RECOV
    } phase_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CE_ON,
        ST_ALE_CLR_A,
        ST_SPARE_ON,
        ST_WP_OFF,
        ST_CMD_LOAD,
        ST_ALE_SET,
        ST_ADDR_0,
        ST_ADDR_1,
        ST_ADDR_2,
        ST_ALE_CLR_B,
        ST_DATA,
        ST_CMD_PROG,
        ST_CMD_STAT,
        ST_POLL,
        ST_WP_ON,
        ST_STAT_FINAL,
        ST_CE_OFF,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic       valid;
        logic [3:0] port;
        logic [7:0] data;
        logic       is_rd;
        logic       is_cmd;
    } bus_req_t;

endpackage

// File: rtl/nps_byte_pick.sv
module nps_byte_pick #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = WORD_W / LANE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);

    logic [LANE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign lane = lanes[sel];

endmodule

// File: rtl/nps_bus_engine.sv
module nps_bus_engine
    import nps_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int MIN_STROBE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_req_t         req,
    input  logic [CNT_W-1:0] cfg_strobe_len,
    input  logic [CNT_W-1:0] cfg_recov_len,
    output logic             ack,
    output logic [7:0]       rdata,
    output logic             bus_cs_n,
    output logic             bus_wr_n,
    output logic             bus_rd_n,
    output logic [3:0]       bus_port,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    output logic             bus_cmd_lat_n
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] rec;
        logic [3:0]       port;
        logic [7:0]       wdata;
        logic             is_rd;
        logic             is_cmd;
        logic [7:0]       rdata;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        ack = 1'b0;
        case (e_q.phase)
            PH_IDLE: begin
                if (req.valid) begin
                    e_d.phase  = PH_ACT;
                    e_d.cnt    = '0;
                    e_d.port   = req.port;
                    e_d.wdata  = req.data;
                    e_d.is_rd  = req.is_rd;
                    e_d.is_cmd = req.is_cmd;
                    e_d.len    = (cfg_strobe_len < CNT_W'(MIN_STROBE)) ? CNT_W'(MIN_STROBE)
                                                                       : cfg_strobe_len;
                    e_d.rec    = (cfg_recov_len == '0) ? CNT_W'(1) : cfg_recov_len;
                end
            end
            PH_ACT: begin
                if (e_q.cnt == e_q.len - CNT_W'(1)) begin
                    e_d.phase = PH_RECOV;
                    e_d.cnt   = '0;
                    if (e_q.is_rd) begin
                        e_d.rdata = bus_rdata;
                    end
                end else begin
                    e_d.cnt = e_q.cnt + CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (e_q.cnt == e_q.rec - CNT_W'(1)) begin
                    ack       = 1'b1;
                    e_d.phase = PH_IDLE;
                    e_d.cnt   = '0;
                end else begin
                    e_d.cnt = e_q.cnt + CNT_W'(1);
                end
            end
            default: e_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    logic active;
    assign active        = (e_q.phase == PH_ACT);
    assign bus_cs_n      = !active;
    assign bus_wr_n      = !(active && !e_q.is_rd);
    assign bus_rd_n      = !(active && e_q.is_rd);
    assign bus_port      = e_q.port;
    assign bus_wdata     = e_q.wdata;
    assign rdata         = e_q.rdata;
    assign bus_cmd_lat_n = !(active && e_q.is_cmd && (e_q.cnt >= CNT_W'(1))
                             && (e_q.cnt <= e_q.len - CNT_W'(2)));

    AST_CMDLAT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cmd_lat_n |-> (!bus_wr_n && !bus_cs_n));                          // R8
    AST_CMDLAT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cmd_lat_n) |-> $past(!bus_wr_n));                            // R8
    AST_CMDLAT_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> $past(bus_cmd_lat_n));                             // R8
    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req.valid |-> (e_q.phase == PH_IDLE));                                 // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!bus_wr_n, !bus_rd_n}));                                     // R9

endmodule

// File: rtl/nps_step_ctrl.sv
module nps_step_ctrl
    import nps_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_BYTES = 32,
    parameter int POLL_W = 16,
    localparam int BYTE_W = $clog2(PAGE_BYTES),
    localparam int IDX_W = BYTE_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [POLL_W-1:0] cfg_poll_limit,
    input  logic [7:0]        data_byte,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [1:0]        lane_sel,
    output bus_req_t          req,
    input  logic              ack,
    input  logic [7:0]        rdata,
    output logic              done,
    output logic              fail
);

    typedef struct packed {
        step_e             step;
        logic              wait_ack;
        logic [BYTE_W-1:0] byte_cnt;
        logic [POLL_W-1:0] poll_cnt;
        logic [ADDR_W-1:0] addr;
        logic              fail;
        logic              tmo;
    } seq_t;

    seq_t s_d, s_q;

    bus_req_t cyc;
    logic     is_bus_step;
    logic [POLL_W:0] poll_next;
    logic [POLL_W:0] poll_lim_eff;

    assign poll_next    = {1'b0, s_q.poll_cnt} + (POLL_W+1)'(1);
    assign poll_lim_eff = (cfg_poll_limit == '0) ? (POLL_W+1)'(1) : {1'b0, cfg_poll_limit};

    // Bus cycle described by the current step
    always_comb begin
        cyc         = '0;
        is_bus_step = 1'b1;
        case (s_q.step)
            ST_CE_ON:      cyc.port = PORT_CE_ON;
            ST_ALE_CLR_A:  cyc.port = PORT_ALE_CLR;
            ST_SPARE_ON:   cyc.port = PORT_SPARE_ON;
            ST_WP_OFF:     cyc.port = PORT_WP_OFF;
            ST_CMD_LOAD:   begin cyc.port = PORT_CMD; cyc.data = OP_LOAD;   cyc.is_cmd = 1'b1; end
            ST_ALE_SET:    cyc.port = PORT_ALE_SET;
            ST_ADDR_0:     begin cyc.port = PORT_DATA; cyc.data = s_q.addr[7:0]; end
            ST_ADDR_1:     begin cyc.port = PORT_DATA; cyc.data = s_q.addr[16:9]; end
            ST_ADDR_2:     begin cyc.port = PORT_DATA; cyc.data = {1'b0, s_q.addr[23:17]}; end
            ST_ALE_CLR_B:  cyc.port = PORT_ALE_CLR;
            ST_DATA:       begin cyc.port = PORT_DATA; cyc.data = data_byte; end
            ST_CMD_PROG:   begin cyc.port = PORT_CMD; cyc.data = OP_PROG;   cyc.is_cmd = 1'b1; end
            ST_CMD_STAT:   begin cyc.port = PORT_CMD; cyc.data = OP_STATUS; cyc.is_cmd = 1'b1; end
            ST_POLL:       begin cyc.port = PORT_DATA; cyc.is_rd = 1'b1; end
            ST_WP_ON:      cyc.port = PORT_WP_ON;
            ST_STAT_FINAL: begin cyc.port = PORT_DATA; cyc.is_rd = 1'b1; end
            ST_CE_OFF:     cyc.port = PORT_CE_OFF;
            default:       is_bus_step = 1'b0;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        req       = cyc;
        req.valid = 1'b0;
        if (s_q.step == ST_IDLE) begin
            if (start) begin
                s_d.step     = ST_CE_ON;
                s_d.wait_ack = 1'b0;
                s_d.byte_cnt = '0;
                s_d.poll_cnt = '0;
                s_d.addr     = dest_addr;
                s_d.fail     = 1'b0;
                s_d.tmo      = 1'b0;
            end
        end else if (s_q.step == ST_DONE) begin
            s_d.step = ST_IDLE;
        end else if (is_bus_step) begin
            if (!s_q.wait_ack) begin
                req.valid    = 1'b1;
                s_d.wait_ack = 1'b1;
            end else if (ack) begin
                s_d.wait_ack = 1'b0;
                case (s_q.step)
                    ST_DATA: begin
                        if (s_q.byte_cnt == BYTE_W'(PAGE_BYTES - 1)) begin
                            s_d.step = ST_CMD_PROG;
                        end else begin
                            s_d.byte_cnt = s_q.byte_cnt + BYTE_W'(1);
                        end
                    end
                    ST_POLL: begin
                        if (rdata[READY_BIT]) begin
                            s_d.step = ST_WP_ON;
                        end else if (poll_next >= poll_lim_eff) begin
                            s_d.tmo  = 1'b1;
                            s_d.fail = 1'b1;
                            s_d.step = ST_WP_ON;
                        end else begin
                            s_d.poll_cnt = poll_next[POLL_W-1:0];
                        end
                    end
                    ST_STAT_FINAL: begin
                        s_d.fail = s_q.tmo | rdata[FAIL_BIT];
                        s_d.step = ST_CE_OFF;
                    end
                    default: s_d.step = step_e'(s_q.step + 5'd1);
                endcase
            end
        end else begin
            s_d.step = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_idx  = s_q.byte_cnt[BYTE_W-1:2];
    assign lane_sel = s_q.byte_cnt[1:0];
    assign done     = (s_q.step == ST_DONE);
    assign fail     = s_q.fail;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                        // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && s_q.step != ST_IDLE) |=> $stable(s_q.addr));                 // R11
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_POLL) |-> ({1'b0, s_q.poll_cnt} < poll_lim_eff));      // R10
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_IDLE) |-> !req.valid);                                 // R1

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_BYTES = 32,
    parameter int CNT_W = 8,
    parameter int POLL_W = 16,
    localparam int IDX_W = $clog2(PAGE_BYTES) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [CNT_W-1:0]  cfg_strobe_len,
    input  logic [CNT_W-1:0]  cfg_recov_len,
    input  logic [POLL_W-1:0] cfg_poll_limit,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [31:0]       buf_word,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic [3:0]        bus_port,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              bus_cmd_lat_n,
    output logic              done,
    output logic              fail
);

    bus_req_t   req;
    logic       ack;
    logic [7:0] rdata;
    logic [1:0] lane_sel;
    logic [7:0] data_byte;

    nps_byte_pick #(.WORD_W(32), .LANE_W(8)) u_pick (
        .word (buf_word),
        .sel  (lane_sel),
        .lane (data_byte)
    );

    nps_step_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .POLL_W     (POLL_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .dest_addr      (dest_addr),
        .cfg_poll_limit (cfg_poll_limit),
        .data_byte      (data_byte),
        .buf_idx        (buf_idx),
        .lane_sel       (lane_sel),
        .req            (req),
        .ack            (ack),
        .rdata          (rdata),
        .done           (done),
        .fail           (fail)
    );

    nps_bus_engine #(.CNT_W(CNT_W)) u_eng (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req),
        .cfg_strobe_len (cfg_strobe_len),
        .cfg_recov_len  (cfg_recov_len),
        .ack            (ack),
        .rdata          (rdata),
        .bus_cs_n       (bus_cs_n),
        .bus_wr_n       (bus_wr_n),
        .bus_rd_n       (bus_rd_n),
        .bus_port       (bus_port),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bus_cmd_lat_n  (bus_cmd_lat_n)
    );

endmodule

// File: tb/nand_prog_seq_bench.sv
`timescale 1ns/1ps
module nand_prog_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] dest_addr = '0;
    logic [7:0]  cfg_strobe_len = 8'd3;
    logic [7:0]  cfg_recov_len = 8'd1;
    logic [15:0] cfg_poll_limit = 16'd8;
    logic [2:0]  buf_idx;
    logic [31:0] buf_word;
    logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_cmd_lat_n;
    logic [3:0]  bus_port;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        done, fail;

    always #10 clk = ~clk;

    logic [31:0] buf_mem [8];
    assign buf_word = buf_mem[buf_idx];

    nand_prog_seq u_nand_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr),
        .cfg_strobe_len(cfg_strobe_len), .cfg_recov_len(cfg_recov_len),
        .cfg_poll_limit(cfg_poll_limit), .buf_idx(buf_idx), .buf_word(buf_word),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_cmd_lat_n(bus_cmd_lat_n), .done(done), .fail(fail)
    );

    int tests = 0;
    int fails = 0;

    // Transaction log captured by the monitor
    localparam int LOG_N = 256;
    logic [3:0] t_port [LOG_N];
    logic       t_rd   [LOG_N];
    logic [7:0] t_data [LOG_N];
    logic       t_lat  [LOG_N];
    logic       t_lat_first [LOG_N];
    logic       t_lat_last  [LOG_N];
    logic [2:0] t_idx  [LOG_N];
    int         t_len  [LOG_N];
    int         t_gap  [LOG_N];
    int n_tx = 0;
    int act_len = 0, gap_cnt = 0, cur_gap = 0;
    logic cur_lat = 0, cur_first = 0, cur_lastlat = 0, prev_cs_low = 0;
    logic [3:0] cur_port; logic cur_rd; logic [7:0] cur_data; logic [2:0] cur_idx;
    int done_cnt = 0, done_run = 0, done_run_max = 0;
    logic fail_at_done = 0;
    int busy_reads = 0;
    logic dev_fail = 0;
    int rd_seen = 0;

    always @(negedge clk) begin
        bus_rdata <= (rd_seen < busy_reads) ? 8'h00 : {1'b0, 1'b1, 5'b0, dev_fail};
        if (!bus_cs_n) begin
            if (!prev_cs_low) begin
                cur_gap = gap_cnt;
                act_len = 0;
                cur_lat = 0;
                cur_first = !bus_cmd_lat_n;
            end
            act_len++;
            if (!bus_cmd_lat_n) cur_lat = 1;
            cur_lastlat = !bus_cmd_lat_n;
            cur_port = bus_port; cur_rd = !bus_rd_n; cur_data = bus_wdata; cur_idx = buf_idx;
            prev_cs_low = 1;
        end else begin
            if (prev_cs_low && n_tx < LOG_N) begin
                t_port[n_tx] = cur_port; t_rd[n_tx] = cur_rd; t_data[n_tx] = cur_data;
                t_lat[n_tx] = cur_lat; t_lat_first[n_tx] = cur_first;
                t_lat_last[n_tx] = cur_lastlat; t_len[n_tx] = act_len;
                t_gap[n_tx] = cur_gap; t_idx[n_tx] = cur_idx;
                if (cur_rd) rd_seen++;
                n_tx++;
                gap_cnt = 0;
            end
            if (prev_cs_low) gap_cnt = 0;
            gap_cnt++;
            prev_cs_low = 0;
        end
        if (done) begin
            done_run++;
            if (done_run == 1) begin done_cnt++; fail_at_done = fail; end
            if (done_run > done_run_max) done_run_max = done_run;
        end else begin
            done_run = 0;
        end
    end

    task automatic check(input string rq, input string what, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Expected transaction list
    logic [3:0] e_port [LOG_N];
    logic       e_rd   [LOG_N];
    logic [7:0] e_data [LOG_N];
    logic       e_cmd  [LOG_N];
    string      e_req  [LOG_N];
    int n_exp;

    task automatic push_exp(input logic [3:0] p, input logic rd, input logic [7:0] d,
                            input logic c, input string rq);
        e_port[n_exp] = p; e_rd[n_exp] = rd; e_data[n_exp] = d; e_cmd[n_exp] = c;
        e_req[n_exp] = rq; n_exp++;
    endtask

    task automatic build_exp(input logic [23:0] a, input int polls);
        n_exp = 0;
        push_exp(4'h8, 0, 8'h00, 0, "R2"); push_exp(4'h3, 0, 8'h00, 0, "R2");
        push_exp(4'h4, 0, 8'h00, 0, "R2"); push_exp(4'h7, 0, 8'h00, 0, "R2");
        push_exp(4'h1, 0, 8'h80, 1, "R3"); push_exp(4'h2, 0, 8'h00, 0, "R3");
        push_exp(4'h0, 0, a[7:0], 0, "R3"); push_exp(4'h0, 0, a[16:9], 0, "R3");
        push_exp(4'h0, 0, {1'b0, a[23:17]}, 0, "R3"); push_exp(4'h3, 0, 8'h00, 0, "R3");
        for (int n = 0; n < 32; n++) begin
            push_exp(4'h0, 0, buf_mem[n/4][8*(n%4) +: 8], 0, "R4");
        end
        push_exp(4'h1, 0, 8'h10, 1, "R5"); push_exp(4'h1, 0, 8'h70, 1, "R5");
        for (int p = 0; p < polls; p++) push_exp(4'h0, 1, 8'h00, 0, "R6");
        push_exp(4'h6, 0, 8'h00, 0, "R7"); push_exp(4'h0, 1, 8'h00, 0, "R7");
        push_exp(4'h9, 0, 8'h00, 0, "R7");
    endtask

    task automatic fill_buf(input logic [31:0] seed);
        for (int w = 0; w < 8; w++) buf_mem[w] = seed ^ (32'h01020304 * (w + 1)) ^ {w[7:0], 24'h5a00a5};
    endtask

    task automatic run_op(input logic [23:0] a, input int busy, input logic dfail,
                          input logic mid_start);
        int guard;
        n_tx = 0; rd_seen = 0; done_cnt = 0; done_run_max = 0;
        busy_reads = busy; dev_fail = dfail;
        @(negedge clk);
        dest_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (60) @(negedge clk);
            dest_addr = ~a; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 40000) begin @(negedge clk); guard++; end
        repeat (30) @(negedge clk);
    endtask

    task automatic check_seq(input int polls, input logic exp_fail, input string tag);
        int mism;
        int sl, rl;
        sl = (cfg_strobe_len < 3) ? 3 : int'(cfg_strobe_len);
        rl = (cfg_recov_len == 0) ? 1 : int'(cfg_recov_len);
        check("R6", {tag, " transaction count"}, n_tx, n_exp);
        mism = 0;
        for (int i = 0; i < n_exp && i < n_tx; i++) begin
            tests++;
            if (t_port[i] !== e_port[i] || t_rd[i] !== e_rd[i] ||
                (!e_rd[i] && t_data[i] !== e_data[i])) begin
                fails++;
                $display("FAIL %s %s tx %0d: actual port %0h rd %0b data %0h expected port %0h rd %0b data %0h",
                         e_req[i], tag, i, t_port[i], t_rd[i], t_data[i], e_port[i], e_rd[i], e_data[i]);
            end
            if (e_cmd[i] != (t_lat[i] && !t_lat_first[i] && !t_lat_last[i]) ||
                (!e_cmd[i] && t_lat[i])) mism++;
            if (t_len[i] != sl || (i > 0 && t_gap[i] != rl + 1)) mism++;
        end
        check("R8", {tag, " command latch windows wrong"}, mism == 0 ? 0 : 1, 0);
        for (int i = 10; i < 42 && i < n_tx; i++) begin
            if (t_idx[i] != 3'((i - 10) / 4)) mism++;
        end
        check("R4", {tag, " buf_idx tracking"}, mism, 0);
        check("R9", {tag, " strobe length tx1"}, t_len[1], sl);
        check("R9", {tag, " gap tx1"}, t_gap[1], rl + 1);
        check("R11", {tag, " done count"}, done_cnt, 1);
        check("R11", {tag, " done width"}, done_run_max, 1);
        check("R7", {tag, " fail at done"}, fail_at_done, exp_fail);
        check("R11", {tag, " fail held"}, fail, exp_fail);
    endtask

    task automatic t_reset;
        check("R1", "cs_n idle", bus_cs_n, 1);
        check("R1", "wr_n idle", bus_wr_n, 1);
        check("R1", "rd_n idle", bus_rd_n, 1);
        check("R1", "cmd_lat_n idle", bus_cmd_lat_n, 1);
        check("R1", "done idle", done, 0);
    endtask

    task automatic t_pass_basic;
        fill_buf(32'hdeadbeef);
        cfg_strobe_len = 8'd3; cfg_recov_len = 8'd1; cfg_poll_limit = 16'd8;
        build_exp(24'hA5C3F1, 3);
        run_op(24'hA5C3F1, 2, 1'b0, 1'b0);
        check_seq(3, 1'b0, "pass_basic");
    endtask

    task automatic t_fail_bit;
        fill_buf(32'h13579bdf);
        cfg_strobe_len = 8'd5; cfg_recov_len = 8'd3; cfg_poll_limit = 16'd4;
        build_exp(24'h3E07FF, 1);
        run_op(24'h3E07FF, 0, 1'b1, 1'b0);
        check_seq(1, 1'b1, "fail_bit_R7");
    endtask

    task automatic t_timeout;
        fill_buf(32'h0f0f00ff);
        cfg_strobe_len = 8'd1; cfg_recov_len = 8'd0; cfg_poll_limit = 16'd3;
        build_exp(24'h00FF00, 3);
        run_op(24'h00FF00, 100, 1'b0, 1'b0);
        check_seq(3, 1'b1, "timeout_R10");
    endtask

    task automatic t_timeout_zero;
        fill_buf(32'h89abcdef);
        cfg_strobe_len = 8'd4; cfg_recov_len = 8'd2; cfg_poll_limit = 16'd0;
        build_exp(24'h812345, 1);
        run_op(24'h812345, 5, 1'b0, 1'b0);
        check_seq(1, 1'b1, "timeout_limit0_R10");
    endtask

    task automatic t_edge_ready;
        fill_buf(32'h2468ace0);
        cfg_strobe_len = 8'd3; cfg_recov_len = 8'd2; cfg_poll_limit = 16'd3;
        build_exp(24'hFFFFFF, 3);
        run_op(24'hFFFFFF, 2, 1'b0, 1'b0);
        check_seq(3, 1'b0, "ready_on_last_poll_R6");
    endtask

    task automatic t_start_busy;
        fill_buf(32'h55aa33cc);
        cfg_strobe_len = 8'd3; cfg_recov_len = 8'd1; cfg_poll_limit = 16'd8;
        build_exp(24'h1C2B3A, 2);
        run_op(24'h1C2B3A, 1, 1'b0, 1'b1);
        check_seq(2, 1'b0, "start_while_busy_R11");
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        fill_buf(32'h0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_pass_basic();
        t_reset();
        t_fail_bit();
        t_timeout();
        t_timeout_zero();
        t_edge_ready();
        t_start_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule